// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block sits next to a processor core and decides when a pending prioritised interrupt is taken. When it takes one, it runs the exception entry as a multi-cycle state machine. A source posts a 3-bit level with a one-cycle set strobe, and the block holds that level in a pending register. While idle, the block compares the pending level with the interrupt mask in the live status register. Once it accepts a level, it latches the status register, stack pointer, program counter, vector base and a variant select, and clears the pending register.

It then requests an acknowledge that carries the level. It waits for either a device vector or the all-ones autovector indication. It pushes the stack frame as 16-bit writes through a simple request/ready memory port. Last, it reads the handler address from the vector table as two 16-bit reads. A one-cycle done pulse presents the new program counter, status register and stack pointer, together with the fixed cycle cost of the entry. The core uses this pulse to leave any stopped state.

The variant select picks the frame layout. Value 0 gives the short frame with no format word. Value 1 adds a format word. Values 2 and 3 also add a second, throwaway frame when the master bit is set.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a pending level L is accepted when L is 7, or when L is strictly greater than the mask in status bits 10:8. A pending level that fails this test stays pending and raises no acknowledge. It is accepted later, as soon as the mask falls below it. Level 0 is never accepted.
- R2: After acceptance, `ack_req_o` is held high with `ack_level_o` equal to the accepted level until the cycle in which `ack_rdy_i` is high. If `ack_vec_i` is 0xFFFFFFFF, the vector number is 24 plus the level. Otherwise the vector number is `ack_vec_i[7:0]`.
- R3: The new status word equals the latched one with these changes: bits 15 and 14 (trace) are cleared, bit 13 (supervisor) is set, and bits 10:8 hold the accepted level. All other bits are kept, except bit 12 as given in R6.
- R4: With variant 0 and entry stack pointer S, three writes are made in this order: PC[31:16] at S-4, PC[15:0] at S-2, and the old status word at S-6. The new stack pointer is S-6.
- R5: With variant 1, 2 or 3, four writes are made in this order: the format word (vector number shifted left by 2) at S-2, PC[31:16] at S-6, PC[15:0] at S-4, and the old status word at S-8. The new stack pointer is S-8.
- R6: With variant 2 or 3 and status bit 12 (master) set, four more writes follow the R5 frame: 0x1000 OR the low 12 bits of the format word at S-10, PC[31:16] at S-14, PC[15:0] at S-12, and the old status word with bit 13 forced to 1 at S-16. The new stack pointer is S-16 and bit 12 of the new status word is cleared.
- R7: After the frame is written, two reads are made: the first at VBR + 4 × vector, the second at that address + 2. The new PC is the first read word followed by the second.
- R8: When the sequence ends, `done_o` is high for exactly one cycle, with `cost_o` equal to 44 and the new PC, status word and stack pointer valid. These outputs hold their values until the next entry completes.
- R9: The pending register is cleared on acceptance. A set strobe that arrives while the block is busy is ignored, so the same interrupt is not taken twice.
- R10: After reset the block is idle: busy, acknowledge, memory request and done are low, and nothing is pending. `busy_o` is high from the cycle after acceptance up to the cycle in which done rises, and no acknowledge or memory request is made while it is low.
- R11: A memory request whose `mem_rdy_i` is low is held with the same address, write data and direction until the cycle in which `mem_rdy_i` is high. The frame contents do not depend on stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_set_i | input | 1 | Strobe that loads the pending level while idle |
| irq_level_i | input | 3 | Level posted with the strobe |
| sr_i | input | 16 | Live status register |
| sp_i | input | 32 | Live stack pointer |
| pc_i | input | 32 | Program counter to stack |
| vbr_i | input | 32 | Vector table base |
| variant_i | input | 2 | Frame layout select |
| ack_req_o | output | 1 | Acknowledge request |
| ack_level_o | output | 3 | Level being acknowledged |
| ack_rdy_i | input | 1 | Acknowledge answered this cycle |
| ack_vec_i | input | 32 | Device vector, or all ones for autovector |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the 16-bit access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_rdy_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | One-cycle completion pulse; clears stopped state |
| new_pc_o | output | 32 | Handler address |
| new_sr_o | output | 16 | Status word after entry |
| new_sp_o | output | 32 | Stack pointer after the frame |
| cost_o | output | 8 | Cycle cost of the entry |

## Verification
Every level from 1 to 7 is tried against every mask from 0 to 7. This separates the strict greater-than test from greater-or-equal, and it shows the level-7 override. It also shows that a masked level stays pending until the mask is lowered. Each variant is run with the master bit clear and with it set, which tells the short frame, the format-word frame and the doubled frame apart by write count, addresses and words. Device vectors are mixed with the all-ones autovector answer, and some device vectors have high bits set so that truncation to 8 bits is tested. Slow acknowledges, memory stalls on alternate cycles and a set strobe sent while busy show that the frame does not depend on timing and that one request gives only one entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int LVL_W = 3;
  localparam int SR_W  = 16;
  localparam int VEC_W = 8;
  localparam int AUTOVEC_BASE = 24;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACK  = 3'd1,
    ST_PUSH = 3'd2,
    ST_VHI  = 3'd3,
    ST_VLO  = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    PS_FMT = 2'd0,
    PS_PCH = 2'd1,
    PS_PCL = 2'd2,
    PS_SR  = 2'd3
  } push_e;

  function automatic logic level_beats_mask(input logic [LVL_W-1:0] lvl,
                                            input logic [LVL_W-1:0] mask);
    return (lvl == {LVL_W{1'b1}}) || (lvl > mask);
  endfunction

  function automatic logic [VEC_W-1:0] vector_of(input logic [31:0] ack,
                                                 input logic [LVL_W-1:0] lvl);
    if (ack == 32'hFFFF_FFFF) return VEC_W'(AUTOVEC_BASE) + VEC_W'(lvl);
    return ack[VEC_W-1:0];
  endfunction

  function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0] sr,
                                               input logic [LVL_W-1:0] lvl,
                                               input logic drop_master);
    logic [SR_W-1:0] r;
    r = sr;
    r[15:14] = 2'b00;
    r[13] = 1'b1;
    r[10:8] = lvl;
    if (drop_master) r[12] = 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] fmt_word(input logic [VEC_W-1:0] vec,
                                           input logic second);
    logic [15:0] w;
    w = {6'b0, vec, 2'b00};
    if (second) w = {4'h1, w[11:0]};
    return w;
  endfunction

endpackage

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
  import irq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             idle_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic [LVL_W-1:0] pend_o,
  output logic             accept_o
);
  logic [LVL_W-1:0] pend_q;

  assign accept_o = idle_i && level_beats_mask(pend_q, mask_i);
  assign pend_o   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= '0;
    else if (accept_o)         pend_q <= '0;
    else if (idle_i && set_i)  pend_q <= level_i;
  end

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && pend_q == '0) |=> (pend_q == '0));
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
  import irq_seq_pkg::*;
(
  input  logic [31:0]      ack_vec_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [VEC_W-1:0] vec_o
);
  assign vec_o = vector_of(ack_vec_i, level_i);
endmodule

// File: rtl/irq_frame_step.sv
module irq_frame_step
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  push_e             step_i,
  input  logic              second_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic [31:0]       pc_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       wdata_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  localparam logic [ADDR_W-1:0] WORD_B = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LONG_B = ADDR_W'(4);

  always_comb begin
    addr_o    = sp_i - WORD_B;
    sp_next_o = sp_i - WORD_B;
    wdata_o   = '0;
    unique case (step_i)
      PS_FMT: wdata_o = fmt_word(vec_i, second_i);
      PS_PCH: begin
        addr_o    = sp_i - LONG_B;
        sp_next_o = sp_i;
        wdata_o   = pc_i[31:16];
      end
      PS_PCL: begin
        sp_next_o = sp_i - LONG_B;
        wdata_o   = pc_i[15:0];
      end
      PS_SR:  wdata_o = second_i ? (sr_i | 16'h2000) : sr_i;
      default: wdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int COST_W     = 8,
  parameter int ENTRY_COST = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_set_i,
  input  logic [2:0]        irq_level_i,
  input  logic [15:0]       sr_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [31:0]       pc_i,
  input  logic [ADDR_W-1:0] vbr_i,
  input  logic [1:0]        variant_i,
  output logic              ack_req_o,
  output logic [2:0]        ack_level_o,
  input  logic              ack_rdy_i,
  input  logic [31:0]       ack_vec_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       new_pc_o,
  output logic [15:0]       new_sr_o,
  output logic [ADDR_W-1:0] new_sp_o,
  output logic [COST_W-1:0] cost_o
);
  localparam logic [ADDR_W-1:0] HALF_OFS = ADDR_W'(2);

  seq_st_e             st_q;
  push_e               step_q;
  logic                second_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [SR_W-1:0]     sr_q;
  logic [ADDR_W-1:0]   sp_q, vbr_q;
  logic [31:0]         pc_q;
  logic [1:0]          var_q;
  logic [VEC_W-1:0]    vec_q;
  logic [15:0]         pch_q;
  logic                done_q;
  logic [31:0]         new_pc_q;
  logic [SR_W-1:0]     new_sr_q;
  logic [ADDR_W-1:0]   new_sp_q;

  // named internal events
  logic                idle_w, accept_w, frame_end_w, want_second_w;
  logic [LVL_W-1:0]    pend_w;
  logic [VEC_W-1:0]    vec_w;
  logic [ADDR_W-1:0]   push_addr_w, sp_next_w, vec_addr_w;
  logic [15:0]         push_data_w;

  assign idle_w = (st_q == ST_IDLE);

  irq_pend_ctl u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (irq_set_i),
    .level_i  (irq_level_i),
    .idle_i   (idle_w),
    .mask_i   (sr_i[10:8]),
    .pend_o   (pend_w),
    .accept_o (accept_w)
  );

  irq_vec_sel u_vec (
    .ack_vec_i (ack_vec_i),
    .level_i   (lvl_q),
    .vec_o     (vec_w)
  );

  irq_frame_step #(.ADDR_W(ADDR_W)) u_step (
    .step_i    (step_q),
    .second_i  (second_q),
    .sp_i      (sp_q),
    .sr_i      (sr_q),
    .pc_i      (pc_q),
    .vec_i     (vec_q),
    .addr_o    (push_addr_w),
    .wdata_o   (push_data_w),
    .sp_next_o (sp_next_w)
  );

  assign vec_addr_w    = vbr_q + {{(ADDR_W-VEC_W-2){1'b0}}, vec_q, 2'b00};
  assign want_second_w = var_q[1] && sr_q[12] && !second_q;
  assign frame_end_w   = (st_q == ST_PUSH) && (step_q == PS_SR) && mem_rdy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      step_q   <= PS_FMT;
      second_q <= 1'b0;
      lvl_q    <= '0;
      sr_q     <= '0;
      sp_q     <= '0;
      vbr_q    <= '0;
      pc_q     <= '0;
      var_q    <= '0;
      vec_q    <= '0;
      pch_q    <= '0;
      done_q   <= 1'b0;
      new_pc_q <= '0;
      new_sr_q <= '0;
      new_sp_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept_w) begin
          lvl_q  <= pend_w;
          sr_q   <= sr_i;
          sp_q   <= sp_i;
          pc_q   <= pc_i;
          vbr_q  <= vbr_i;
          var_q  <= variant_i;
          st_q   <= ST_ACK;
        end
        ST_ACK: if (ack_rdy_i) begin
          vec_q    <= vec_w;
          second_q <= 1'b0;
          step_q   <= (var_q == 2'd0) ? PS_PCH : PS_FMT;
          st_q     <= ST_PUSH;
        end
        ST_PUSH: if (mem_rdy_i) begin
          sp_q <= sp_next_w;
          if (step_q == PS_SR) begin
            if (want_second_w) begin
              second_q <= 1'b1;
              step_q   <= PS_FMT;
            end else begin
              st_q <= ST_VHI;
            end
          end else begin
            step_q <= push_e'(step_q + 2'd1);
          end
        end
        ST_VHI: if (mem_rdy_i) begin
          pch_q <= mem_rdata_i;
          st_q  <= ST_VLO;
        end
        ST_VLO: if (mem_rdy_i) begin
          new_pc_q <= {pch_q, mem_rdata_i};
          new_sr_q <= entry_sr(sr_q, lvl_q, second_q);
          new_sp_q <= sp_q;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_req_o   = (st_q == ST_ACK);
  assign ack_level_o = lvl_q;
  assign mem_req_o   = (st_q == ST_PUSH) || (st_q == ST_VHI) || (st_q == ST_VLO);
  assign mem_we_o    = (st_q == ST_PUSH);
  assign mem_addr_o  = (st_q == ST_PUSH) ? push_addr_w :
                       (st_q == ST_VLO)  ? (vec_addr_w + HALF_OFS) : vec_addr_w;
  assign mem_wdata_o = (st_q == ST_PUSH) ? push_data_w : 16'h0000;
  assign busy_o      = !idle_w;
  assign done_o      = done_q;
  assign new_pc_o    = new_pc_q;
  assign new_sr_o    = new_sr_q;
  assign new_sp_o    = new_sp_q;
  assign cost_o      = COST_W'(ENTRY_COST);

  assert_accept_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req_o) |-> (ack_level_o == 3'd7 || ack_level_o > $past(sr_i[10:8])));

  assert_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && !ack_rdy_i) |=> (ack_req_o && $stable(ack_level_o)));

  assert_entry_sr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (new_sr_o[15:14] == 2'b00 && new_sr_o[13]));

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (pend_w == '0));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ack_req_o && !mem_req_o));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_wdata_o) && $stable(mem_we_o)));

  assert_frame_then_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_w && !want_second_w) |=> (mem_req_o && !mem_we_o));
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        irq_set_i = 1'b0;
  logic [2:0]  irq_level_i = '0;
  logic [15:0] sr_i = '0;
  logic [31:0] sp_i = '0, pc_i = '0, vbr_i = '0;
  logic [1:0]  variant_i = '0;
  logic        ack_req_o;
  logic [2:0]  ack_level_o;
  logic        ack_rdy_i = 1'b0;
  logic [31:0] ack_vec_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_rdy_i = 1'b0;
  logic        busy_o, done_o;
  logic [31:0] new_pc_o, new_sp_o;
  logic [15:0] new_sr_o;
  logic [7:0]  cost_o;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_set_i(irq_set_i), .irq_level_i(irq_level_i),
    .sr_i(sr_i), .sp_i(sp_i), .pc_i(pc_i), .vbr_i(vbr_i), .variant_i(variant_i),
    .ack_req_o(ack_req_o), .ack_level_o(ack_level_o), .ack_rdy_i(ack_rdy_i),
    .ack_vec_i(ack_vec_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_rdy_i(mem_rdy_i), .busy_o(busy_o), .done_o(done_o), .new_pc_o(new_pc_o),
    .new_sr_o(new_sr_o), .new_sp_o(new_sp_o), .cost_o(cost_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_word(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // responders
  bit stall_cfg = 0, stall_tog = 0;
  int ack_delay = 0, ack_wait = 0, n_acks = 0, n_bad_busy = 0;
  logic [31:0] wa [0:15];
  logic [15:0] wd [0:15];
  logic [31:0] ra [0:3];
  int nw = 0, nr = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (ack_req_o && !busy_o) n_bad_busy++;
      if (ack_req_o) begin
        if (ack_wait > 0) begin ack_rdy_i = 1'b0; ack_wait--; end
        else begin ack_rdy_i = 1'b1; n_acks++; end
      end else begin
        ack_rdy_i = 1'b0;
        ack_wait = ack_delay;
      end
      if (mem_req_o) begin
        stall_tog = ~stall_tog;
        if (stall_cfg && stall_tog) mem_rdy_i = 1'b0;
        else begin
          mem_rdy_i = 1'b1;
          mem_rdata_i = rom_word(mem_addr_o);
          if (mem_we_o) begin
            if (nw < 16) begin wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; end
            nw++;
          end else begin
            if (nr < 4) ra[nr] = mem_addr_o;
            nr++;
          end
        end
      end else mem_rdy_i = 1'b0;
    end
  end

  task automatic launch(input logic [2:0] lvl, input logic [15:0] sr,
                        input logic [31:0] sp, input logic [31:0] vbr,
                        input logic [31:0] pc, input logic [1:0] vr,
                        input logic [31:0] vecval);
    @(negedge clk);
    sr_i = sr; sp_i = sp; vbr_i = vbr; pc_i = pc; variant_i = vr; ack_vec_i = vecval;
    irq_set_i = 1'b1; irq_level_i = lvl; nw = 0; nr = 0;
    @(negedge clk);
    irq_set_i = 1'b0;
  endtask

  task automatic finish_check(input logic [2:0] lvl, input logic [15:0] sr,
                              input logic [31:0] sp, input logic [31:0] vbr,
                              input logic [31:0] pc, input logic [1:0] vr,
                              input logic [31:0] vecval, input bit poke);
    logic [31:0] ea [0:15];
    logic [15:0] ed [0:15];
    int ne = 0;
    logic [31:0] s;
    logic [7:0] vec;
    logic [15:0] fw, esr;
    bit second, got, poked;
    int acks0;
    logic [31:0] va;
    acks0 = n_acks;
    got = 0; poked = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (poke && busy_o && !poked) begin irq_set_i = 1'b1; irq_level_i = 3'd7; poked = 1; end
      else irq_set_i = 1'b0;
      if (done_o) begin got = 1; break; end
    end
    irq_set_i = 1'b0;
    check(got, "R8 done seen", 32'(got), 32'd1);
    vec = (vecval == 32'hFFFF_FFFF) ? 8'(24 + lvl) : vecval[7:0];
    fw = 16'(vec) * 16'd4;
    second = vr[1] && sr[12];
    s = sp;
    if (vr != 2'd0) begin s -= 2; ea[ne] = s; ed[ne] = fw; ne++; end
    s -= 4; ea[ne] = s; ed[ne] = pc[31:16]; ne++; ea[ne] = s + 2; ed[ne] = pc[15:0]; ne++;
    s -= 2; ea[ne] = s; ed[ne] = sr; ne++;
    if (second) begin
      s -= 2; ea[ne] = s; ed[ne] = 16'h1000 + (fw % 16'h1000); ne++;
      s -= 4; ea[ne] = s; ed[ne] = pc[31:16]; ne++; ea[ne] = s + 2; ed[ne] = pc[15:0]; ne++;
      s -= 2; ea[ne] = s; ed[ne] = sr | 16'h2000; ne++;
    end
    check(nw == ne, second ? "R6 write count" : (vr == 0 ? "R4 write count" : "R5 write count"),
          32'(nw), 32'(ne));
    for (int k = 0; k < ne && k < nw; k++) begin
      check(wa[k] == ea[k], second && k >= 4 ? "R6 addr" : (vr == 0 ? "R4 addr" : "R5 addr"),
            wa[k], ea[k]);
      check(wd[k] == ed[k], second && k >= 4 ? "R6 data" : (vr == 0 ? "R4 data" : "R5 data"),
            32'(wd[k]), 32'(ed[k]));
    end
    check(new_sp_o == s, "R4/R5/R6 new sp", new_sp_o, s);
    va = vbr + 32'(vec) * 4;
    check(nr == 2, "R7 read count", 32'(nr), 32'd2);
    check(ra[0] == va && ra[1] == va + 2, "R7 read addr (R2 vector)", ra[0], va);
    check(new_pc_o == {rom_word(va), rom_word(va + 2)}, "R7 new pc", new_pc_o,
          {rom_word(va), rom_word(va + 2)});
    esr = (sr & ~16'hC700) | 16'h2000 | (16'(lvl) << 8);
    if (second) esr = esr & ~16'h1000;
    check(new_sr_o == esr, second ? "R6 R3 new sr" : "R3 new sr", 32'(new_sr_o), 32'(esr));
    check(cost_o == 8'd44, "R8 cost", 32'(cost_o), 32'd44);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", 32'(done_o), 32'd0);
    check(new_pc_o == {rom_word(va), rom_word(va + 2)}, "R8 pc held", new_pc_o,
          {rom_word(va), rom_word(va + 2)});
    if (poke) begin
      repeat (6) @(negedge clk);
      check(n_acks == acks0 + 1 && !busy_o, "R9 set while busy ignored", 32'(n_acks - acks0), 32'd1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !ack_req_o && !mem_req_o && !done_o, "R10 reset idle",
          {busy_o, ack_req_o, mem_req_o, done_o}, 32'd0);
    repeat (5) @(negedge clk);
    check(n_acks == 0 && !busy_o, "R10 nothing pending after reset", 32'(n_acks), 32'd0);

    // level 0 never taken
    launch(3'd0, 16'h0000, 32'h1000, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFF);
    repeat (6) @(negedge clk);
    check(n_acks == 0 && !busy_o, "R1 level 0 not taken", 32'(n_acks), 32'd0);

    // sweep levels x masks
    for (int l = 1; l < 8; l++) begin
      for (int m = 0; m < 8; m++) begin
        logic [15:0] sr;
        int a0;
        sr = 16'h0015 | (16'(m) << 8);
        a0 = n_acks;
        launch(3'(l), sr, 32'h0000_2000 + 32'(l * 64), 32'h0000_0400, 32'h00AB_1230 + 32'(m),
               2'd0, 32'hFFFF_FFFF);
        if (l == 7 || l > m) begin
          finish_check(3'(l), sr, 32'h0000_2000 + 32'(l * 64), 32'h0000_0400,
                       32'h00AB_1230 + 32'(m), 2'd0, 32'hFFFF_FFFF, 1'b0);
        end else begin
          repeat (6) @(negedge clk);
          check(n_acks == a0 && !busy_o, "R1 masked level stays pending", 32'(n_acks - a0), 32'd0);
          sr_i = 16'h0015;
          finish_check(3'(l), 16'h0015, 32'h0000_2000 + 32'(l * 64), 32'h0000_0400,
                       32'h00AB_1230 + 32'(m), 2'd0, 32'hFFFF_FFFF, 1'b0);
        end
      end
    end

    // variants x master bit x vector kinds, with stalls and slow acks
    for (int v = 0; v < 4; v++) begin
      for (int mb = 0; mb < 2; mb++) begin
        for (int vk = 0; vk < 2; vk++) begin
          logic [15:0] sr;
          logic [31:0] vv;
          sr = 16'hC0A3 | (mb ? 16'h1000 : 16'h0);
          vv = vk ? 32'h1234_56C7 : 32'hFFFF_FFFF;
          stall_cfg = (vk == 1);
          ack_delay = v;
          launch(3'd5, sr, 32'h0080_0000 + 32'(v * 256), 32'h0001_0000, 32'hDEAD_BEE0 + 32'(mb),
                 2'(v), vv);
          finish_check(3'd5, sr, 32'h0080_0000 + 32'(v * 256), 32'h0001_0000,
                       32'hDEAD_BEE0 + 32'(mb), 2'(v), vv, 1'b0);
        end
      end
    end

    // R11 stalls plus R9 set during busy, R2 slow ack
    stall_cfg = 1; ack_delay = 3;
    launch(3'd2, 16'h1101, 32'h0000_0100, 32'h0000_0000, 32'h0000_4000, 2'd2, 32'h0000_0040);
    finish_check(3'd2, 16'h1101, 32'h0000_0100, 32'h0000_0000, 32'h0000_4000, 2'd2,
                 32'h0000_0040, 1'b1);
    stall_cfg = 0; ack_delay = 0;
    launch(3'd7, 16'h1700, 32'h0000_0010, 32'h0000_0200, 32'h1111_2222, 2'd3, 32'hFFFF_FFFF);
    finish_check(3'd7, 16'h1700, 32'h0000_0010, 32'h0000_0200, 32'h1111_2222, 2'd3,
                 32'hFFFF_FFFF, 1'b1);

    check(n_bad_busy == 0, "R10 busy during ack", 32'(n_bad_busy), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule